// File: doc/BRIEF.md
# Calendar Clock Register Core

This block keeps wall-clock time and a calendar: seconds, minutes, hours, day of week, day of month, month and a two-digit year. Software reaches it through two byte ports. A write to the index port picks a register. Later data-port writes and reads then go to that register. The time is held internally as plain binary in 24-hour form. It is converted at the data port to the representation that control register B selects: BCD or binary, and 12-hour or 24-hour. Because the conversion happens at the port, changing the format bits changes how the stored time is presented, and the time itself is untouched.

An external one-cycle tick enable marks each second. A tick starts an update sequence. The update-in-progress flag rises first. The counters advance a fixed number of cycles later. The flag then stays high for a further hold window. When the flag falls, an update-ended flag is latched for software. Software can freeze the counters through control register B so that it can load a new time without a race. A power-good input feeds a sticky validity flag that software can read.

Top module: `rtc_calendar_core`

## Requirements
- R1: After reset the time reads 00:00:00 with weekday 1, day 1, month 1 and year 00. Control register B (index 11) reads 0x02 (BCD, 24-hour, not frozen). Control register A (index 10) reads 0x00. Flag register C (index 12) reads 0x00.
- R2: An index-port write uses only the low 7 bits of the written byte as the register index, so bit 7 has no effect on which register is addressed. The time registers are at indices 0 (seconds), 2 (minutes), 4 (hours), 6 (weekday), 7 (day of month), 8 (month) and 9 (year).
- R3: A tick seen while idle and not frozen sets register A bit 7 (update in progress) from the next cycle. The counters advance at the clock edge LEAD_CYCLES cycles after the tick edge. Bit 7 clears after LEAD_CYCLES+HOLD_CYCLES cycles.
- R4: Each update adds one second. Seconds wrap 59→0 into minutes, minutes wrap 59→0 into hours, and hours wrap 23→0 into the day. The weekday counts 1 to 7 and returns to 1.
- R5: At a day carry, the day of month returns to 1 after the last day of its month: 30 days for months 4, 6, 9 and 11, and 31 for the other months. February has 29 days when the year is divisible by 4 and 28 otherwise. Month 12 returns to 1 into the year, and year 99 returns to 00.
- R6: Register B bit 2 selects the port format: 0 is BCD and 1 is binary. Reads and writes of the time registers use the selected format.
- R7: Register B bit 1 selects the hour mode: 1 is 24-hour (0–23) and 0 is 12-hour (1–12, with hour-byte bit 7 set for PM). In 12-hour mode, 11 PM is followed by 12 AM, and 11 AM is followed by 12 PM.
- R8: While register B bit 7 is 1, ticks are ignored: the update-in-progress flag stays low and the counters hold. Clearing the bit lets the next tick update the time.
- R9: Register C bit 4 is set when an update sequence ends. A data-port read of register C returns the flag and then clears it. A frozen tick does not set it.
- R10: Register D (index 13) bit 7 reads 0 if power-good has been low since the previous read of D, or since reset. Otherwise it reads 1. Each read of D while power is good re-arms it to 1.
- R11: A software write to a time register in the same cycle as an advance takes effect for that register. The other registers still advance.
- R12: A tick that arrives during an update sequence is ignored. Writes to register A bit 7 and to registers C and D have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | One-cycle pulse marking each second |
| pwr_ok | input | 1 | Power-good indication; low marks a power loss |
| idx_we | input | 1 | Index-port write strobe |
| dat_we | input | 1 | Data-port write strobe |
| dat_re | input | 1 | Data-port read strobe; carries read side effects |
| wdata | input | 8 | Byte written to the index or data port |
| rdata | output | 8 | Byte of the currently indexed register |

## Verification
Two functions can meet at one clock edge: a software write to a time register, and the once-per-second advance that the sequencer issues LEAD_CYCLES cycles after a tick. The bench counts cycles from the tick edge and asserts the data-port write exactly at the advance edge. It does this once with the seconds register selected and once with minutes selected. It judges the result by whether the written register holds the written byte while the other register shows the single-second advance. A second collision happens when the update-ended flag and a read of register C fall together. That case is guarded by the flag assertions, and the bench checks the read-then-clear order through the port.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

   localparam int unsigned IDX_SEC  = 0;
   localparam int unsigned IDX_MIN  = 2;
   localparam int unsigned IDX_HOUR = 4;
   localparam int unsigned IDX_WDAY = 6;
   localparam int unsigned IDX_MDAY = 7;
   localparam int unsigned IDX_MON  = 8;
   localparam int unsigned IDX_YEAR = 9;
   localparam int unsigned IDX_CTLA = 10;
   localparam int unsigned IDX_CTLB = 11;
   localparam int unsigned IDX_FLGC = 12;
   localparam int unsigned IDX_FLGD = 13;

   localparam int unsigned NUM_FIELDS = 7;

   typedef enum logic [2:0] {
      F_SEC  = 3'd0,
      F_MIN  = 3'd1,
      F_HOUR = 3'd2,
      F_WDAY = 3'd3,
      F_MDAY = 3'd4,
      F_MON  = 3'd5,
      F_YEAR = 3'd6
   } rtc_field_e;

   typedef struct packed {
      logic [6:0] year;
      logic [3:0] mon;
      logic [4:0] mday;
      logic [2:0] wday;
      logic [4:0] hour;
      logic [5:0] min;
      logic [5:0] sec;
   } rtc_time_t;

   localparam rtc_time_t TIME_RESET = '{year: 7'd0, mon: 4'd1, mday: 5'd1,
                                        wday: 3'd1, hour: 5'd0, min: 6'd0,
                                        sec: 6'd0};

   // register index of a time field, used by the write decode loop
   function automatic int unsigned field_reg(input int unsigned f);
      case (f)
         0:       return IDX_SEC;
         1:       return IDX_MIN;
         2:       return IDX_HOUR;
         3:       return IDX_WDAY;
         4:       return IDX_MDAY;
         5:       return IDX_MON;
         default: return IDX_YEAR;
      endcase
   endfunction

   function automatic logic [7:0] to_bcd(input logic [6:0] v);
      logic [3:0] tens;
      logic [3:0] ones;
      tens = 4'(v / 7'd10);
      ones = 4'(v % 7'd10);
      return {tens, ones};
   endfunction

   function automatic logic [6:0] from_bcd(input logic [7:0] b);
      return {3'b000, b[7:4]} * 7'd10 + {3'b000, b[3:0]};
   endfunction

   function automatic logic [7:0] encode(input logic [6:0] v, input logic bin);
      return bin ? {1'b0, v} : to_bcd(v);
   endfunction

   function automatic logic [6:0] decode(input logic [7:0] b, input logic bin);
      return bin ? b[6:0] : from_bcd(b);
   endfunction

   function automatic logic [4:0] month_days(input logic [3:0] mon,
                                             input logic [1:0] yr_lo);
      case (mon)
         4'd2:                    return (yr_lo == 2'd0) ? 5'd29 : 5'd28;
         4'd4, 4'd6, 4'd9, 4'd11: return 5'd30;
         default:                 return 5'd31;
      endcase
   endfunction

endpackage

// File: rtl/rtc_update_seq.sv
module rtc_update_seq #(
   parameter int unsigned LEAD_CYCLES = 4,
   parameter int unsigned HOLD_CYCLES = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic freeze,
   output logic uip,
   output logic adv,
   output logic done
);
   localparam int unsigned MAXC = (LEAD_CYCLES > HOLD_CYCLES) ? LEAD_CYCLES : HOLD_CYCLES;
   localparam int unsigned CW   = $clog2(MAXC + 1);

   initial begin
      assert (LEAD_CYCLES >= 1 && HOLD_CYCLES >= 1)
         else $error("rtc_update_seq: lead and hold windows need at least one cycle");
   end

   typedef enum logic [1:0] {S_IDLE, S_LEAD, S_HOLD} seq_state_e;

   seq_state_e      st;
   logic [CW-1:0]   cnt;
   logic            at_point;

   assign at_point = (st == S_LEAD) && (cnt == '0);
   assign adv      = at_point && !freeze;
   assign done     = (st == S_HOLD) && (cnt == '0);
   assign uip      = (st != S_IDLE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st  <= S_IDLE;
         cnt <= '0;
      end else begin
         case (st)
            S_IDLE: begin
               if (tick && !freeze) begin
                  st  <= S_LEAD;
                  cnt <= CW'(LEAD_CYCLES - 1);
               end
            end
            S_LEAD: begin
               if (cnt == '0) begin
                  if (freeze) begin
                     st <= S_IDLE;
                  end else begin
                     st  <= S_HOLD;
                     cnt <= CW'(HOLD_CYCLES - 1);
                  end
               end else begin
                  cnt <= cnt - CW'(1);
               end
            end
            S_HOLD: begin
               if (cnt == '0) st <= S_IDLE;
               else           cnt <= cnt - CW'(1);
            end
            default: st <= S_IDLE;
         endcase
      end
   end

   // R3: an accepted tick raises the busy flag on the next cycle
   a_r3_uip_rises: assert property (@(posedge clk) disable iff (!rst_n)
      (!uip && tick && !freeze) |=> uip);

   // R3: the end of the hold window drops the busy flag
   a_r3_done_ends: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !uip);

   // R8: a frozen idle sequencer does not start
   a_r8_frozen_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (!uip && freeze) |=> !uip);

endmodule

// File: rtl/rtc_hour_codec.sv
module rtc_hour_codec
   import rtc_cal_pkg::*;
#(
   parameter bit SUPPORT_12H = 1'b1
) (
   input  logic [4:0] h24,
   input  logic       bin_mode,
   input  logic       h24_mode,
   output logic [7:0] rd_byte,
   input  logic [7:0] wr_byte,
   output logic [4:0] wr_h24
);
   generate
      if (SUPPORT_12H) begin : g_12h
         logic       pm;
         logic [4:0] h12;
         logic [7:0] enc12;
         logic       pmw;
         logic [4:0] h12w;

         always_comb begin
            pm      = (h24 >= 5'd12);
            h12     = (h24 == 5'd0) ? 5'd12 : ((h24 > 5'd12) ? h24 - 5'd12 : h24);
            enc12   = encode({2'b00, h12}, bin_mode);
            rd_byte = h24_mode ? encode({2'b00, h24}, bin_mode) : (enc12 | {pm, 7'b0});

            pmw  = wr_byte[7];
            h12w = 5'(decode({1'b0, wr_byte[6:0]}, bin_mode));
            if (h24_mode)
               wr_h24 = 5'(decode(wr_byte, bin_mode));
            else if (h12w == 5'd12)
               wr_h24 = pmw ? 5'd12 : 5'd0;
            else
               wr_h24 = pmw ? h12w + 5'd12 : h12w;
         end
      end else begin : g_24h
         logic unused_mode;
         assign unused_mode = h24_mode;
         assign rd_byte     = encode({2'b00, h24}, bin_mode);
         assign wr_h24      = 5'(decode(wr_byte, bin_mode));
      end
   endgenerate

endmodule

// File: rtl/rtc_time_regs.sv
module rtc_time_regs
   import rtc_cal_pkg::*;
(
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  adv,
   input  logic [NUM_FIELDS-1:0] wr_en,
   input  rtc_time_t             wr_val,
   output rtc_time_t             cur
);
   rtc_time_t nxt;
   rtc_time_t upd;
   logic      sec_w, min_w, hour_w, mday_w, mon_w, year_w;

   // one-second advance with the carry chain
   always_comb begin
      nxt    = cur;
      sec_w  = (cur.sec  >= 6'd59);
      min_w  = (cur.min  >= 6'd59);
      hour_w = (cur.hour >= 5'd23);
      mday_w = (cur.mday >= month_days(cur.mon, cur.year[1:0]));
      mon_w  = (cur.mon  >= 4'd12);
      year_w = (cur.year >= 7'd99);

      nxt.sec = sec_w ? 6'd0 : cur.sec + 6'd1;
      if (sec_w)
         nxt.min = min_w ? 6'd0 : cur.min + 6'd1;
      if (sec_w && min_w)
         nxt.hour = hour_w ? 5'd0 : cur.hour + 5'd1;
      if (sec_w && min_w && hour_w) begin
         nxt.wday = (cur.wday >= 3'd7) ? 3'd1 : cur.wday + 3'd1;
         nxt.mday = mday_w ? 5'd1 : cur.mday + 5'd1;
         if (mday_w) begin
            nxt.mon = mon_w ? 4'd1 : cur.mon + 4'd1;
            if (mon_w)
               nxt.year = year_w ? 7'd0 : cur.year + 7'd1;
         end
      end
   end

   // a software write overrides the advance, field by field
   always_comb begin
      upd = adv ? nxt : cur;
      if (wr_en[F_SEC])  upd.sec  = wr_val.sec;
      if (wr_en[F_MIN])  upd.min  = wr_val.min;
      if (wr_en[F_HOUR]) upd.hour = wr_val.hour;
      if (wr_en[F_WDAY]) upd.wday = wr_val.wday;
      if (wr_en[F_MDAY]) upd.mday = wr_val.mday;
      if (wr_en[F_MON])  upd.mon  = wr_val.mon;
      if (wr_en[F_YEAR]) upd.year = wr_val.year;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) cur <= TIME_RESET;
      else        cur <= upd;
   end

   // R4: seconds wrap to zero on an advance
   a_r4_sec_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && !wr_en[F_SEC] && cur.sec == 6'd59) |=> (cur.sec == 6'd0));

   // R4: no advance and no write leaves the time unchanged
   a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!adv && wr_en == '0) |=> $stable(cur));

   // R11: a write lands even in an advance cycle
   a_r11_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en[F_SEC] |=> (cur.sec == $past(wr_val.sec)));

endmodule

// File: rtl/rtc_calendar_core.sv
module rtc_calendar_core
   import rtc_cal_pkg::*;
#(
   parameter int unsigned LEAD_CYCLES = 4,
   parameter int unsigned HOLD_CYCLES = 4,
   parameter bit          SUPPORT_12H = 1'b1,
   parameter int unsigned ADDR_W      = 7
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick_en,
   input  logic       pwr_ok,
   input  logic       idx_we,
   input  logic       dat_we,
   input  logic       dat_re,
   input  logic [7:0] wdata,
   output logic [7:0] rdata
);
   initial begin
      assert (ADDR_W >= 4 && ADDR_W <= 8)
         else $error("rtc_calendar_core: index width must be 4 to 8 bits");
   end

   logic [ADDR_W-1:0]     idx;
   logic [6:0]            ctla_lo;
   logic [7:0]            ctlb;
   logic                  uf;
   logic                  lost;
   logic                  uip, adv, done;
   logic                  fmt_bin, h24m, freeze;
   logic [NUM_FIELDS-1:0] wr_en;
   logic [6:0]            gdec;
   logic [4:0]            hour_wr;
   logic [7:0]            hour_rd;
   logic                  sel_a, sel_b, sel_c, sel_d;
   rtc_time_t             wr_val;
   rtc_time_t             cur;

   assign fmt_bin = ctlb[2];
   assign h24m    = ctlb[1];
   assign freeze  = ctlb[7];

   assign sel_a = (idx == ADDR_W'(IDX_CTLA));
   assign sel_b = (idx == ADDR_W'(IDX_CTLB));
   assign sel_c = (idx == ADDR_W'(IDX_FLGC));
   assign sel_d = (idx == ADDR_W'(IDX_FLGD));

   generate
      for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_wsel
         assign wr_en[f] = dat_we && (idx == ADDR_W'(field_reg(f)));
      end
   endgenerate

   assign gdec = decode(wdata, fmt_bin);

   always_comb begin
      wr_val.sec  = gdec[5:0];
      wr_val.min  = gdec[5:0];
      wr_val.hour = hour_wr;
      wr_val.wday = gdec[2:0];
      wr_val.mday = gdec[4:0];
      wr_val.mon  = gdec[3:0];
      wr_val.year = gdec;
   end

   rtc_update_seq #(
      .LEAD_CYCLES (LEAD_CYCLES),
      .HOLD_CYCLES (HOLD_CYCLES)
   ) u_seq (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick   (tick_en),
      .freeze (freeze),
      .uip    (uip),
      .adv    (adv),
      .done   (done)
   );

   rtc_hour_codec #(
      .SUPPORT_12H (SUPPORT_12H)
   ) u_hour (
      .h24      (cur.hour),
      .bin_mode (fmt_bin),
      .h24_mode (h24m),
      .rd_byte  (hour_rd),
      .wr_byte  (wdata),
      .wr_h24   (hour_wr)
   );

   rtc_time_regs u_time (
      .clk    (clk),
      .rst_n  (rst_n),
      .adv    (adv),
      .wr_en  (wr_en),
      .wr_val (wr_val),
      .cur    (cur)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idx     <= '0;
         ctla_lo <= 7'h00;
         ctlb    <= 8'h02;
         uf      <= 1'b0;
         lost    <= 1'b1;
      end else begin
         if (idx_we)          idx     <= wdata[ADDR_W-1:0];
         if (dat_we && sel_a) ctla_lo <= wdata[6:0];
         if (dat_we && sel_b) ctlb    <= wdata;
         if (done)                 uf <= 1'b1;
         else if (dat_re && sel_c) uf <= 1'b0;
         if (!pwr_ok)              lost <= 1'b1;
         else if (dat_re && sel_d) lost <= 1'b0;
      end
   end

   always_comb begin
      case (idx)
         ADDR_W'(IDX_SEC):  rdata = encode({1'b0, cur.sec}, fmt_bin);
         ADDR_W'(IDX_MIN):  rdata = encode({1'b0, cur.min}, fmt_bin);
         ADDR_W'(IDX_HOUR): rdata = hour_rd;
         ADDR_W'(IDX_WDAY): rdata = encode({4'b0, cur.wday}, fmt_bin);
         ADDR_W'(IDX_MDAY): rdata = encode({2'b0, cur.mday}, fmt_bin);
         ADDR_W'(IDX_MON):  rdata = encode({3'b0, cur.mon}, fmt_bin);
         ADDR_W'(IDX_YEAR): rdata = encode(cur.year, fmt_bin);
         ADDR_W'(IDX_CTLA): rdata = {uip, ctla_lo};
         ADDR_W'(IDX_CTLB): rdata = ctlb;
         ADDR_W'(IDX_FLGC): rdata = {3'b000, uf, 4'b0000};
         ADDR_W'(IDX_FLGD): rdata = {~lost, 7'b0};
         default:           rdata = 8'h00;
      endcase
   end

   // R2: the index register takes the low bits of the written byte
   a_r2_index_low_bits: assert property (@(posedge clk) disable iff (!rst_n)
      idx_we |=> (idx == $past(wdata[ADDR_W-1:0])));

   // R9: the end of an update raises the flag
   a_r9_uf_on_done: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> uf);

   // R9: a read of register C clears the flag unless an update ends
   a_r9_uf_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (dat_re && sel_c && !done) |=> !uf);

   // R10: a power loss invalidates the time
   a_r10_loss_marks: assert property (@(posedge clk) disable iff (!rst_n)
      !pwr_ok |=> (rdata[7] == 1'b0 || !sel_d));

endmodule

// File: tb/rtc_calendar_core_bench.sv
module rtc_calendar_core_bench;
   localparam int LEAD = 4;
   localparam int HOLD = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_en = 1'b0;
   logic       pwr_ok = 1'b1;
   logic       idx_we = 1'b0;
   logic       dat_we = 1'b0;
   logic       dat_re = 1'b0;
   logic [7:0] wdata = 8'h00;
   logic [7:0] rdata;

   int  n_chk  = 0;
   int  n_fail = 0;
   bit  finished = 1'b0;

   always #4 clk = ~clk;

   rtc_calendar_core u_rtc_calendar_core (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick_en (tick_en),
      .pwr_ok  (pwr_ok),
      .idx_we  (idx_we),
      .dat_we  (dat_we),
      .dat_re  (dat_re),
      .wdata   (wdata),
      .rdata   (rdata)
   );

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %02h expected %02h", req, act, exp);
      end
   endtask

   task automatic set_idx(input logic [7:0] i);
      @(negedge clk); idx_we = 1'b1; wdata = i;
      @(negedge clk); idx_we = 1'b0;
   endtask

   task automatic wr(input logic [7:0] i, input logic [7:0] v);
      set_idx(i);
      dat_we = 1'b1; wdata = v;
      @(negedge clk); dat_we = 1'b0;
   endtask

   task automatic rd(input logic [7:0] i, output logic [7:0] v);
      set_idx(i);
      v = rdata;
      dat_re = 1'b1;
      @(negedge clk); dat_re = 1'b0;
   endtask

   task automatic rd_chk(input string req, input logic [7:0] i, input logic [7:0] exp);
      logic [7:0] v;
      rd(i, v);
      check(req, v, exp);
   endtask

   // ends one cycle after the tick edge
   task automatic pulse_tick();
      @(negedge clk); tick_en = 1'b1;
      @(negedge clk); tick_en = 1'b0;
   endtask

   task automatic settle();
      repeat (LEAD + HOLD + 3) @(negedge clk);
   endtask

   task automatic full_tick();
      pulse_tick();
      settle();
   endtask

   task automatic t_reset();
      rd_chk("R1 sec", 8'd0, 8'h00);
      rd_chk("R1 min", 8'd2, 8'h00);
      rd_chk("R1 hour", 8'd4, 8'h00);
      rd_chk("R1 wday", 8'd6, 8'h01);
      rd_chk("R1 mday", 8'd7, 8'h01);
      rd_chk("R1 mon", 8'd8, 8'h01);
      rd_chk("R1 year", 8'd9, 8'h00);
      rd_chk("R1 regA", 8'd10, 8'h00);
      rd_chk("R1 regB", 8'd11, 8'h02);
      rd_chk("R1 regC", 8'd12, 8'h00);
      rd_chk("R10 after reset", 8'd13, 8'h00);
      rd_chk("R10 re-armed", 8'd13, 8'h80);
   endtask

   task automatic t_index();
      wr(8'h82, 8'h45);
      rd_chk("R2 bit7 ignored on write", 8'h02, 8'h45);
      rd_chk("R2 bit7 ignored on read", 8'h82, 8'h45);
   endtask

   task automatic t_uip_timing();
      wr(8'd0, 8'h10);
      set_idx(8'd10);
      pulse_tick();
      check("R3 uip after tick", {7'b0, rdata[7]}, 8'h01);
      repeat (LEAD + HOLD - 1) @(negedge clk);
      check("R3 uip end of hold", {7'b0, rdata[7]}, 8'h01);
      @(negedge clk);
      check("R3 uip falls", {7'b0, rdata[7]}, 8'h00);
      settle();
      rd_chk("R3 one second", 8'd0, 8'h11);
   endtask

   task automatic t_adv_timing();
      wr(8'd0, 8'h20);
      set_idx(8'd0);
      pulse_tick();
      repeat (LEAD - 1) @(negedge clk);
      check("R3 before advance edge", rdata, 8'h20);
      @(negedge clk);
      check("R3 after advance edge", rdata, 8'h21);
      settle();
   endtask

   task automatic t_time_carry();
      wr(8'd4, 8'h05); wr(8'd2, 8'h10); wr(8'd0, 8'h59);
      full_tick();
      rd_chk("R4 minute carry sec", 8'd0, 8'h00);
      rd_chk("R4 minute carry min", 8'd2, 8'h11);
      rd_chk("R4 minute carry hour", 8'd4, 8'h05);
      wr(8'd4, 8'h23); wr(8'd2, 8'h59); wr(8'd0, 8'h59);
      wr(8'd6, 8'h07); wr(8'd8, 8'h01); wr(8'd7, 8'h10);
      full_tick();
      rd_chk("R4 day carry sec", 8'd0, 8'h00);
      rd_chk("R4 day carry min", 8'd2, 8'h00);
      rd_chk("R4 day carry hour", 8'd4, 8'h00);
      rd_chk("R4 weekday wrap", 8'd6, 8'h01);
      rd_chk("R4 day of month", 8'd7, 8'h11);
   endtask

   task automatic date_case(input logic [7:0] d, input logic [7:0] m, input logic [7:0] y,
                            input logic [7:0] ed, input logic [7:0] em, input logic [7:0] ey);
      wr(8'd9, y); wr(8'd8, m); wr(8'd7, d);
      wr(8'd4, 8'h23); wr(8'd2, 8'h59); wr(8'd0, 8'h59);
      full_tick();
      rd_chk("R5 mday", 8'd7, ed);
      rd_chk("R5 mon", 8'd8, em);
      rd_chk("R5 year", 8'd9, ey);
   endtask

   task automatic t_calendar();
      date_case(8'h28, 8'h02, 8'h04, 8'h29, 8'h02, 8'h04);
      date_case(8'h29, 8'h02, 8'h04, 8'h01, 8'h03, 8'h04);
      date_case(8'h28, 8'h02, 8'h03, 8'h01, 8'h03, 8'h03);
      date_case(8'h30, 8'h04, 8'h07, 8'h01, 8'h05, 8'h07);
      date_case(8'h30, 8'h01, 8'h05, 8'h31, 8'h01, 8'h05);
      date_case(8'h31, 8'h12, 8'h99, 8'h01, 8'h01, 8'h00);
   endtask

   task automatic t_format();
      wr(8'd11, 8'h06);
      wr(8'd0, 8'h3B);
      wr(8'd2, 8'h2D);
      rd_chk("R6 binary read", 8'd0, 8'h3B);
      wr(8'd11, 8'h02);
      rd_chk("R6 same second in BCD", 8'd0, 8'h59);
      rd_chk("R6 binary write read as BCD", 8'd2, 8'h45);
   endtask

   task automatic t_hour12();
      wr(8'd11, 8'h00);
      wr(8'd4, 8'h91); wr(8'd2, 8'h59); wr(8'd0, 8'h59);
      full_tick();
      rd_chk("R7 11PM to 12AM", 8'd4, 8'h12);
      wr(8'd11, 8'h02);
      rd_chk("R7 midnight in 24h", 8'd4, 8'h00);
      wr(8'd11, 8'h00);
      wr(8'd4, 8'h11); wr(8'd2, 8'h59); wr(8'd0, 8'h59);
      full_tick();
      rd_chk("R7 11AM to 12PM", 8'd4, 8'h92);
      wr(8'd11, 8'h02);
      rd_chk("R7 noon in 24h", 8'd4, 8'h12);
   endtask

   task automatic t_freeze();
      logic [7:0] v;
      rd(8'd12, v);
      wr(8'd11, 8'h82);
      wr(8'd0, 8'h20);
      set_idx(8'd10);
      pulse_tick();
      check("R8 no uip while frozen", {7'b0, rdata[7]}, 8'h00);
      settle();
      rd_chk("R8 seconds held", 8'd0, 8'h20);
      rd_chk("R9 no flag from frozen tick", 8'd12, 8'h00);
      wr(8'd11, 8'h02);
      full_tick();
      rd_chk("R8 resumes", 8'd0, 8'h21);
   endtask

   task automatic t_update_flag();
      logic [7:0] v;
      rd(8'd12, v);
      full_tick();
      rd_chk("R9 flag set", 8'd12, 8'h10);
      rd_chk("R9 flag cleared by read", 8'd12, 8'h00);
   endtask

   task automatic t_valid();
      logic [7:0] v;
      rd(8'd13, v);
      rd_chk("R10 power good", 8'd13, 8'h80);
      @(negedge clk); pwr_ok = 1'b0;
      @(negedge clk); pwr_ok = 1'b1;
      rd_chk("R10 after power loss", 8'd13, 8'h00);
      rd_chk("R10 re-armed after read", 8'd13, 8'h80);
   endtask

   task automatic t_collide();
      wr(8'd2, 8'h05); wr(8'd0, 8'h10);
      set_idx(8'd0);
      pulse_tick();
      repeat (LEAD - 1) @(negedge clk);
      dat_we = 1'b1; wdata = 8'h30;
      @(negedge clk); dat_we = 1'b0;
      check("R11 written seconds win", rdata, 8'h30);
      settle();
      rd_chk("R11 minutes untouched", 8'd2, 8'h05);
      wr(8'd0, 8'h10);
      set_idx(8'd2);
      pulse_tick();
      repeat (LEAD - 1) @(negedge clk);
      dat_we = 1'b1; wdata = 8'h33;
      @(negedge clk); dat_we = 1'b0;
      check("R11 written minutes win", rdata, 8'h33);
      settle();
      rd_chk("R11 seconds still advance", 8'd0, 8'h11);
   endtask

   task automatic t_ignored();
      logic [7:0] v;
      wr(8'd0, 8'h40);
      pulse_tick();
      @(negedge clk); tick_en = 1'b1;
      @(negedge clk); tick_en = 1'b0;
      settle();
      rd_chk("R12 busy tick ignored", 8'd0, 8'h41);
      wr(8'd10, 8'hFF);
      rd_chk("R12 regA bit7 read-only", 8'd10, 8'h7F);
      rd(8'd12, v);
      wr(8'd12, 8'hFF);
      rd_chk("R12 regC write ignored", 8'd12, 8'h00);
      rd(8'd13, v);
      wr(8'd13, 8'h00);
      rd_chk("R12 regD write ignored", 8'd13, 8'h80);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_index();
      t_uip_timing();
      t_adv_timing();
      t_time_carry();
      t_calendar();
      t_format();
      t_hour12();
      t_freeze();
      t_update_flag();
      t_valid();
      t_collide();
      t_ignored();
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL R3 watchdog: actual hung expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end

endmodule